// File: doc/BRIEF.md
# Flexible Data-Rate Frame CRC Unit

This unit computes the frame checksum for a controller that handles both classic and flexible data-rate frames on a shared serial bus. From the start of every frame it runs three bit-serial checksum registers side by side: a 15-bit one, a 17-bit one and a 21-bit one. When the frame format flag and the data length code have been decoded, a selection strobe picks the one register whose value is valid for that frame. The unit then presents that register, its length and the matching payload byte count.

Frame bits arrive one per sample point on a valid/ready stream, and each bit carries two flags. One flag marks a stuff bit. The other marks a bit that belongs to the checksum field. The unit never applies back-pressure: `in_ready` is held high, and a bit is taken on every rising clock edge where `in_valid` is high. Bits outside the checksum field advance the registers. The 15-bit register skips stuff bits. The 17-bit and 21-bit registers take stuff bits too, because flexible-rate frames count the dynamic stuff bits in the checksum.

A transmitter shifts out the frozen `crc_value` most significant bit first. A receiver feeds the checksum field back in with `in_crc` set. The unit compares that field bit by bit with the selected register and reports the result once the last bit has arrived.

Top module: `fdcrc_unit`

## Requirements
- R1: A `sof` pulse without a bit clears all three registers, the selection, the compare counter, `chk_done` and `chk_match` on the next edge. After a reset, or after such a pulse, `crc_value`, `sel_done`, `payload_bytes`, `chk_done` and `chk_match` read 0 and `crc_len` reads 15. If `in_valid` is high in the same cycle as `sof`, that bit is applied to the cleared state.
- R2: The 15-bit register uses x^15+x^14+x^10+x^8+x^7+x^4+x^3+1. At each accepted bit it computes feedback = bit XOR register MSB, shifts left by one, and XORs in the low polynomial terms when the feedback is 1.
- R3: The 17-bit register uses x^17+x^16+x^14+x^13+x^11+x^6+x^4+x^3+x+1 and updates in the same way as in R2.
- R4: The 21-bit register uses x^21+x^20+x^13+x^11+x^7+x^4+x^3+1 and updates in the same way as in R2.
- R5: A `sel_valid` strobe latches `sel_fd` and `sel_dlc` and sets `sel_done`. The selection is:
  - `sel_fd`=0 selects the 15-bit register.
  - `sel_fd`=1 with a code of 10 or below (16 bytes or fewer) selects the 17-bit register.
  - `sel_fd`=1 with a code of 11 or above selects the 21-bit register.
  `crc_len` gives 15, 17 or 21 to match. Before any strobe, `crc_len` is 15 and `crc_value` shows the 15-bit register.
- R6: Outside the checksum field, a bit with `in_stuff`=1 leaves the 15-bit register unchanged but advances the 17-bit and 21-bit registers.
- R7: Bits with `in_crc`=1 change none of the registers, so `crc_value` stays stable during the checksum field.
- R8: The compare takes only checksum-field bits that are not stuff bits. It compares the k-th such bit (k from 0) with bit `crc_len`-1-k of `crc_value`. One cycle after the edge that takes the `crc_len`-th such bit, `chk_done` is high for exactly one cycle. `chk_match` then reads 1 if every bit was equal and 0 otherwise, and it holds that value until the next `sof`.
- R9: Checksum-field bits flagged as stuff bits, and checksum-field bits that arrive after the compare has completed, do not change the compare result and raise no further `chk_done`.
- R10: `payload_bytes` is 0 until a selection is made. For a flexible-rate frame, codes 0–8 give 0–8 bytes and codes 9–15 give 12, 16, 20, 24, 32, 48 and 64 bytes. For a classic frame, codes above 8 give 8 bytes.
- R11: `in_ready` is always 1. While `in_valid` is 0, `in_bit`, `in_stuff` and `in_crc` have no effect.
- R12: The selection may come at any point before the checksum field, including after the last data bit. The value shown is always the chosen register's result over every bit since `sof`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof | input | 1 | Start-of-frame pulse, clears the frame state |
| sel_valid | input | 1 | Strobe that latches the format flag and length code |
| sel_fd | input | 1 | 1 = flexible data-rate frame, 0 = classic frame |
| sel_dlc | input | 4 | Data length code |
| in_valid | input | 1 | Bit stream valid |
| in_ready | output | 1 | Bit stream ready, always 1 |
| in_bit | input | 1 | Bit value at the sample point |
| in_stuff | input | 1 | Marks a stuff bit |
| in_crc | input | 1 | Marks a bit of the checksum field |
| crc_value | output | 21 | Selected register, zero-extended |
| crc_len | output | 5 | Length of the selected checksum (15, 17 or 21) |
| sel_done | output | 1 | A selection has been latched in this frame |
| payload_bytes | output | 7 | Payload bytes for the latched length code |
| chk_done | output | 1 | One-cycle pulse when the received checksum is complete |
| chk_match | output | 1 | Received checksum equalled the selected register |

## Verification
The hardest case to reach from the ports is a late selection in a flexible-rate frame that also carries stuff bits. Here the 17-bit and 21-bit registers have taken bits that the 15-bit register skipped, and the checksum field that follows has its own fixed stuff bits that the compare must skip. The stimulus marks every sixth data bit as a stuff bit, strobes the selection either in mid-frame or only after the last data bit, and then plays back the expected checksum. In flexible-rate frames it places a stuff-flagged bit before every group of four checksum bits. Some runs flip a single checksum bit, either the first or the last, and each run ends with an extra stuff bit and an extra checksum bit after completion to confirm that the result holds.

// File: rtl/fdcrc_pkg.sv
package fdcrc_pkg;
  localparam int NKIND = 3;
  localparam int MAXW  = 21;
  localparam int LENW  = $clog2(MAXW + 1);
  localparam int DLCW  = 4;
  localparam int BYTW  = 7;

  // kind 0: classic 15-bit, kind 1: 17-bit, kind 2: 21-bit
  localparam int unsigned   KW     [NKIND] = '{15, 17, 21};
  localparam logic [MAXW-1:0] KPOLY [NKIND] = '{21'h004599, 21'h01685B, 21'h102899};
  localparam bit            KSTUFF [NKIND] = '{1'b0, 1'b1, 1'b1};

  // highest length code that still uses the shorter flexible checksum (16 bytes)
  localparam logic [DLCW-1:0] DLC_SHORT_MAX = 4'd10;

  typedef logic [1:0] kind_t;

  function automatic logic [BYTW-1:0] dlc_bytes(input logic fd, input logic [DLCW-1:0] dlc);
    logic [BYTW-1:0] b;
    if (dlc <= 4'd8) b = BYTW'(dlc);
    else if (!fd)    b = 7'd8;
    else begin
      case (dlc)
        4'd9:    b = 7'd12;
        4'd10:   b = 7'd16;
        4'd11:   b = 7'd20;
        4'd12:   b = 7'd24;
        4'd13:   b = 7'd32;
        4'd14:   b = 7'd48;
        default: b = 7'd64;
      endcase
    end
    return b;
  endfunction
endpackage

// File: rtl/fdcrc_lfsr.sv
module fdcrc_lfsr #(
  parameter int unsigned W = 15,
  parameter logic [fdcrc_pkg::MAXW-1:0] POLY_FULL = 21'h004599,
  parameter bit USE_STUFF = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic         din,
  input  logic         stuff,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] POLY = POLY_FULL[W-1:0];

  logic [W-1:0] base;
  logic [W-1:0] nxt;
  logic         take;
  logic         fbk;

  always_comb begin
    base = clr ? '0 : q;
    take = step && (USE_STUFF || !stuff);
    fbk  = din ^ base[W-1];
    nxt  = base;
    if (take) nxt = {base[W-2:0], 1'b0} ^ (fbk ? POLY : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/fdcrc_select.sv
module fdcrc_select
  import fdcrc_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         load,
  input  logic                         fd,
  input  logic [DLCW-1:0]              dlc,
  input  logic [NKIND-1:0][MAXW-1:0]   regs,
  output logic [MAXW-1:0]              value,
  output logic [LENW-1:0]              len,
  output logic                         done,
  output logic [BYTW-1:0]              bytes
);
  logic            fd_q;
  logic [DLCW-1:0] dlc_q;
  kind_t           kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fd_q <= 1'b0; dlc_q <= '0; done <= 1'b0;
    end else if (clr) begin
      fd_q <= 1'b0; dlc_q <= '0; done <= 1'b0;
    end else if (load) begin
      fd_q <= fd; dlc_q <= dlc; done <= 1'b1;
    end
  end

  always_comb begin
    if (!done || !fd_q)             kind = 2'd0;
    else if (dlc_q <= DLC_SHORT_MAX) kind = 2'd1;
    else                             kind = 2'd2;
    value = regs[0];
    len   = LENW'(KW[0]);
    for (int k = 0; k < NKIND; k++) begin
      if (kind == kind_t'(k)) begin
        value = regs[k];
        len   = LENW'(KW[k]);
      end
    end
    bytes = done ? dlc_bytes(fd_q, dlc_q) : '0;
  end
endmodule

// File: rtl/fdcrc_rxcmp.sv
module fdcrc_rxcmp
  import fdcrc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            bit_en,
  input  logic            din,
  input  logic [MAXW-1:0] ref_value,
  input  logic [LENW-1:0] len,
  output logic            done,
  output logic            match
);
  logic [LENW-1:0] cnt;
  logic [LENW-1:0] pos;
  logic            err;
  logic            diff;
  logic            active;
  logic            last;

  always_comb begin
    pos    = len - LENW'(1) - cnt;
    diff   = din ^ ref_value[pos];
    active = bit_en && (cnt < len);
    last   = active && (cnt == len - LENW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; err <= 1'b0; done <= 1'b0; match <= 1'b0;
    end else if (clr) begin
      cnt <= '0; err <= 1'b0; done <= 1'b0; match <= 1'b0;
    end else begin
      done <= last;
      if (active) begin
        cnt <= cnt + LENW'(1);
        err <= err | diff;
      end
      if (last) match <= !(err | diff);
    end
  end
endmodule

// File: rtl/fdcrc_unit.sv
module fdcrc_unit
  import fdcrc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sof,
  input  logic            sel_valid,
  input  logic            sel_fd,
  input  logic [DLCW-1:0] sel_dlc,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_bit,
  input  logic            in_stuff,
  input  logic            in_crc,
  output logic [MAXW-1:0] crc_value,
  output logic [LENW-1:0] crc_len,
  output logic            sel_done,
  output logic [BYTW-1:0] payload_bytes,
  output logic            chk_done,
  output logic            chk_match
);
  logic [NKIND-1:0][MAXW-1:0] regs;
  logic                       data_step;
  logic                       cmp_en;

  assign in_ready  = 1'b1;
  assign data_step = in_valid && !in_crc;
  assign cmp_en    = in_valid && in_crc && !in_stuff;

  for (genvar k = 0; k < NKIND; k++) begin : g_crc
    logic [KW[k]-1:0] q;
    fdcrc_lfsr #(
      .W(KW[k]), .POLY_FULL(KPOLY[k]), .USE_STUFF(KSTUFF[k])
    ) u_lfsr (
      .clk(clk), .rst_n(rst_n), .clr(sof), .step(data_step),
      .din(in_bit), .stuff(in_stuff), .q(q)
    );
    assign regs[k] = MAXW'(q);
  end

  fdcrc_select u_sel (
    .clk(clk), .rst_n(rst_n), .clr(sof), .load(sel_valid && !sof),
    .fd(sel_fd), .dlc(sel_dlc), .regs(regs),
    .value(crc_value), .len(crc_len), .done(sel_done), .bytes(payload_bytes)
  );

  fdcrc_rxcmp u_cmp (
    .clk(clk), .rst_n(rst_n), .clr(sof), .bit_en(cmp_en), .din(in_bit),
    .ref_value(crc_value), .len(crc_len), .done(chk_done), .match(chk_match)
  );
endmodule

// File: rtl/fdcrc_unit_chk.sv
module fdcrc_unit_chk
  import fdcrc_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            sof,
  input logic            sel_valid,
  input logic            sel_fd,
  input logic [DLCW-1:0] sel_dlc,
  input logic            in_valid,
  input logic            in_ready,
  input logic            in_bit,
  input logic            in_stuff,
  input logic            in_crc,
  input logic [MAXW-1:0] crc_value,
  input logic [LENW-1:0] crc_len,
  input logic            sel_done,
  input logic [BYTW-1:0] payload_bytes,
  input logic            chk_done,
  input logic            chk_match
);
  // R1
  sof_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof && !in_valid |=> crc_value == '0 && !sel_done && !chk_done && !chk_match);

  // R5
  classic_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid && !sof && !sel_fd |=> sel_done && crc_len == LENW'(15));

  // R7
  crc_field_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_crc && !sof && !sel_valid |=> $stable(crc_value));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_done |=> !chk_done);

  // R9
  stuff_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_crc && in_stuff && !sof |=> !chk_done);

  // R8
  match_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sof && !chk_done && !$past(sof) |=> $stable(chk_match) || chk_done);
endmodule

bind fdcrc_unit fdcrc_unit_chk u_chk (.*);

// File: tb/fdcrc_unit_tb.sv
module fdcrc_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sof = 1'b0, sel_valid = 1'b0, sel_fd = 1'b0;
  logic [3:0]  sel_dlc = '0;
  logic        in_valid = 1'b0, in_bit = 1'b0, in_stuff = 1'b0, in_crc = 1'b0;
  logic        in_ready;
  logic [20:0] crc_value;
  logic [4:0]  crc_len;
  logic        sel_done;
  logic [6:0]  payload_bytes;
  logic        chk_done, chk_match;

  int checks = 0;
  int errors = 0;
  logic [31:0] seed = 32'h1234_5678;
  logic        fb [0:255];
  logic        fs [0:255];

  always #(CLK_PERIOD/2) clk = ~clk;

  fdcrc_unit u_dut (
    .clk(clk), .rst_n(rst_n), .sof(sof), .sel_valid(sel_valid), .sel_fd(sel_fd),
    .sel_dlc(sel_dlc), .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
    .in_stuff(in_stuff), .in_crc(in_crc), .crc_value(crc_value), .crc_len(crc_len),
    .sel_done(sel_done), .payload_bytes(payload_bytes), .chk_done(chk_done),
    .chk_match(chk_match)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic next_rand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[16];
  endfunction

  function automatic logic [20:0] ref_crc(input int w, input logic [20:0] poly,
                                          input int n, input bit incl);
    logic [31:0] r = '0;
    logic [31:0] mask = (32'h1 << w) - 32'h1;
    for (int i = 0; i < n; i++) begin
      if (fs[i] && !incl) continue;
      if (fb[i] ^ r[w-1]) r = ((r << 1) & mask) ^ {11'b0, poly};
      else                r = (r << 1) & mask;
    end
    return r[20:0];
  endfunction

  function automatic int exp_bytes(input bit fd, input int dlc);
    int t [7] = '{12, 16, 20, 24, 32, 48, 64};
    if (dlc <= 8) return dlc;
    if (!fd) return 8;
    return t[dlc-9];
  endfunction

  task automatic drive(input logic v, input logic b, input logic s, input logic c);
    @(negedge clk);
    sof = 1'b0; sel_valid = 1'b0;
    in_valid = v; in_bit = b; in_stuff = s; in_crc = c;
  endtask

  task automatic pulse_sof();
    @(negedge clk);
    sof = 1'b1; sel_valid = 1'b0; in_valid = 1'b0; in_crc = 1'b0; in_stuff = 1'b0;
    @(negedge clk);
    sof = 1'b0;
  endtask

  task automatic t_reset();
    chk(crc_value == 0, "R1", "reset crc_value", crc_value, 0);
    chk(crc_len == 15, "R1", "reset crc_len", crc_len, 15);
    chk(!sel_done && !chk_done && !chk_match && payload_bytes == 0, "R1", "reset flags",
        {sel_done, chk_done, chk_match}, 0);
    chk(in_ready == 1'b1, "R11", "in_ready", in_ready, 1);
  endtask

  // n data bits, selection at bit sel_at (n means after the last bit), corrupt = checksum bit index to flip, -1 none
  task automatic t_frame(input string tag, input int n, input bit fd, input int dlc,
                         input int sel_at, input int corrupt);
    int w; int kind; logic [20:0] expv; logic prev; logic [20:0] held;
    pulse_sof();
    chk(crc_value == 0 && !sel_done, "R1", {tag, " sof clear"}, crc_value, 0);
    prev = 1'b0;
    for (int i = 0; i < n; i++) begin
      fs[i] = (i % 6 == 5);
      fb[i] = fs[i] ? ~prev : next_rand();
      prev = fb[i];
    end
    for (int i = 0; i < n; i++) begin
      drive(1'b1, fb[i], fs[i], 1'b0);
      if (i == sel_at) begin sel_valid = 1'b1; sel_fd = fd; sel_dlc = 4'(dlc); end
      if (i == 3) begin
        chk(!sel_done && crc_len == 15, "R5", {tag, " before select"}, crc_len, 15);
        chk(crc_value == ref_crc(15, 21'h004599, 3, 1'b0), "R2", {tag, " early classic value"},
            crc_value, ref_crc(15, 21'h004599, 3, 1'b0));
      end
    end
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    if (sel_at >= n) begin sel_valid = 1'b1; sel_fd = fd; sel_dlc = 4'(dlc); end
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    kind = !fd ? 0 : (dlc <= 10 ? 1 : 2);
    w = (kind == 0) ? 15 : (kind == 1 ? 17 : 21);
    expv = (kind == 0) ? ref_crc(15, 21'h004599, n, 1'b0) :
           (kind == 1) ? ref_crc(17, 21'h01685B, n, 1'b1) : ref_crc(21, 21'h102899, n, 1'b1);
    chk(sel_done && crc_len == 5'(w), "R5", {tag, " crc_len"}, crc_len, w);
    chk(payload_bytes == 7'(exp_bytes(fd, dlc)), "R10", {tag, " bytes"}, payload_bytes,
        exp_bytes(fd, dlc));
    chk(crc_value == expv, kind == 0 ? "R2 R6" : (kind == 1 ? "R3 R6" : "R4 R6"),
        {tag, sel_at >= n ? " value late select R12" : " value"}, crc_value, expv);
    held = crc_value;
    prev = 1'b1;
    for (int j = 0; j < w; j++) begin
      logic b;
      if (fd && j % 4 == 0) begin
        drive(1'b1, ~prev, 1'b1, 1'b1);
        prev = ~prev;
      end
      b = expv[w-1-j] ^ (j == corrupt);
      if (j == w - 1) chk(!chk_done, "R8", {tag, " no early done"}, chk_done, 0);
      drive(1'b1, b, 1'b0, 1'b1);
      prev = b;
    end
    drive(1'b1, ~prev, 1'b1, 1'b1);
    chk(chk_done, "R8", {tag, " done pulse"}, chk_done, 1);
    chk(chk_match == (corrupt < 0), "R8", {tag, " match"}, chk_match, corrupt < 0);
    chk(crc_value == held, "R7", {tag, " frozen during field"}, crc_value, held);
    drive(1'b1, ~expv[0], 1'b0, 1'b1);
    chk(!chk_done, "R9", {tag, " stuff after done"}, chk_done, 0);
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    chk(!chk_done && chk_match == (corrupt < 0), "R9", {tag, " extra bit ignored"},
        {chk_done, chk_match}, corrupt < 0);
  endtask

  task automatic t_idle_ignore();
    logic [20:0] held;
    pulse_sof();
    for (int i = 0; i < 10; i++) begin fb[i] = next_rand(); fs[i] = 1'b0; end
    for (int i = 0; i < 10; i++) drive(1'b1, fb[i], 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    held = crc_value;
    chk(held == ref_crc(15, 21'h004599, 10, 1'b0), "R2", "idle prelude", held,
        ref_crc(15, 21'h004599, 10, 1'b0));
    for (int i = 0; i < 8; i++) drive(1'b0, 1'(i), 1'(i >> 1), 1'b0);
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    chk(crc_value == held && in_ready, "R11", "valid low ignored", crc_value, held);
  endtask

  task automatic t_dlc_table();
    for (int fd = 0; fd < 2; fd++) begin
      for (int d = 0; d < 16; d++) begin
        pulse_sof();
        chk(payload_bytes == 0, "R10", "bytes before select", payload_bytes, 0);
        @(negedge clk); sel_valid = 1'b1; sel_fd = 1'(fd); sel_dlc = 4'(d);
        @(negedge clk); sel_valid = 1'b0;
        chk(payload_bytes == 7'(exp_bytes(fd != 0, d)), "R10", "dlc table", payload_bytes,
            exp_bytes(fd != 0, d));
      end
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_frame("classic8", 60, 1'b0, 8, 25, -1);
    t_frame("fd16", 90, 1'b1, 10, 30, -1);
    t_frame("fd20late", 120, 1'b1, 11, 120, -1);
    t_frame("fd64bad", 100, 1'b1, 15, 40, 0);
    t_frame("classic3bad", 50, 1'b0, 3, 20, 14);
    t_frame("fd0", 40, 1'b1, 0, 40, -1);
    t_frame("classic15", 70, 1'b0, 15, 10, -1);
    t_idle_ignore();
    t_dlc_table();
    summary();
  end
endmodule